// File: doc/BRIEF.md
# Global-Clock Sequential Element Emulator

This block reproduces the behaviour of one storage element, either an edge-triggered flop or a transparent latch, using only registers on a single fast sampling clock `gclk`. The element's own clock, data, enable, reset, set and clear arrive as ordinary data inputs. They are sampled once per global cycle. A design-clock edge is found by comparing the present clock value with the value held from the previous global cycle. The next output is then picked from held copies of the data and of the output.

A multi-clock design can be rewritten as one of these blocks per storage element, so that the whole design runs on one clock. This suits cycle-based simulation and formal tools. The design clock must change at most once per global cycle. Reset, set and clear act on `q` combinationally in the same global cycle. The mode, width, polarities and the initial and reset values are parameters. There is no streamed data path, so every pin is a plain level.

Top module: `gclk_store_emu`

## Requirements
- R1: While `grst_n` is low, the held output copy, the held data copy and the held design clock are loaded as follows. The output and data copies take `INIT_VAL` on the bits set in `INIT_MASK`. The held clock takes the active clock level. With no override active, a flop then shows `q = INIT_VAL` whatever `dclk` is, and never reports an edge.
- R2: An active edge is reported only when the previous sample is the inactive level and the current sample is the active level. With `CLK_POS=1` this is 0 then 1, and with `CLK_POS=0` it is 1 then 0. The opposite transition leaves `q` unchanged.
- R3: The flop modes are `MODE` 0 (plain), 1 (async reset) and 2 (set/clear). In these modes, on an active-edge cycle, `q` equals the `d` sampled at the previous `gclk` edge.
- R4: In the flop modes, when there is no active edge and no override is active, `q` equals the `q` sampled at the previous `gclk` edge.
- R5: In `MODE` 1, while `arst == RST_POS`, `q` equals `RST_VAL` in that same global cycle. After reset is released, `q` keeps `RST_VAL` until the next active edge.
- R6: In `MODE` 2, each bit of `q` is the edge-selected value, forced to 1 by an active `bit_set` bit and then forced to 0 by an active `bit_clr` bit. When both are active on a bit, clear wins.
- R7: In `MODE` 3 (latch), while `en == EN_POS`, `q` equals the current `d` in the same global cycle.
- R8: In `MODE` 3, while `en != EN_POS`, `q` equals the `q` sampled at the previous `gclk` edge.
- R9: `CLK_POS`, `RST_POS`, `SET_POS`, `CLR_POS` and `EN_POS` each set the active level of their input: 1 means active high and 0 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global sampling clock; the only clock of every register |
| grst_n | input | 1 | Active-low asynchronous load of the initial state |
| dclk | input | 1 | Emulated element's clock, sampled as data |
| d | input | WIDTH | Emulated element's data input |
| en | input | 1 | Latch enable (latch mode only) |
| arst | input | 1 | Asynchronous reset (async-reset mode only) |
| bit_set | input | WIDTH | Per-bit set (set/clear mode only) |
| bit_clr | input | WIDTH | Per-bit clear (set/clear mode only) |
| q | output | WIDTH | Emulated element's output |

## Verification
The bound checker tests the following on every global cycle after reset:
- edge capture and hold in the flop modes, including that the reverse clock transition has no effect;
- the forced reset value;
- the clear-over-set rule, bit by bit;
- latch transparency and latch hold.

Only the bench scenarios can show the rest. These are the initial load with no false edge while `grst_n` is low, a reset value that persists after release, and the same behaviour across every polarity choice. For these, eight instances covering all modes and both polarities share one stimulus and are compared against a behavioural reference.

// File: rtl/gce_pkg.sv
package gce_pkg;

  // Emulated storage element variant
  typedef enum logic [1:0] {
    GCE_FLOP      = 2'd0,
    GCE_FLOP_ARST = 2'd1,
    GCE_FLOP_SR   = 2'd2,
    GCE_LATCH     = 2'd3
  } gce_mode_e;

endpackage

// File: rtl/gce_edge.sv
// Finds an active design-clock edge by comparing against the previous sample.
module gce_edge #(
  parameter bit CLK_POS = 1'b1
) (
  input  logic gclk,
  input  logic grst_n,
  input  logic dclk,
  output logic edge_o
);

  localparam logic [1:0] ACT_PAIR = CLK_POS ? 2'b01 : 2'b10;

  logic prev_clk;

  // Preloaded with the active level so the first cycle never sees an edge
  always_ff @(posedge gclk or negedge grst_n) begin
    if (!grst_n) prev_clk <= CLK_POS;
    else         prev_clk <= dclk;
  end

  assign edge_o = ({prev_clk, dclk} === ACT_PAIR);

endmodule

// File: rtl/gce_hold.sv
// One-global-cycle delay bank; only bits flagged in INIT_MASK get a load value.
module gce_hold #(
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] INIT_VAL  = '0,
  parameter logic [WIDTH-1:0] INIT_MASK = '1
) (
  input  logic             gclk,
  input  logic             grst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (INIT_MASK[b]) begin : g_init
      always_ff @(posedge gclk or negedge grst_n) begin
        if (!grst_n) dout[b] <= INIT_VAL[b];
        else         dout[b] <= din[b];
      end
    end else begin : g_free
      always_ff @(posedge gclk) begin
        dout[b] <= din[b];
      end
    end
  end

endmodule

// File: rtl/gce_qsel.sv
// Next-output selection for the chosen element variant.
module gce_qsel
  import gce_pkg::*;
#(
  parameter gce_mode_e        MODE    = GCE_FLOP,
  parameter int               WIDTH   = 8,
  parameter bit               RST_POS = 1'b1,
  parameter bit               SET_POS = 1'b1,
  parameter bit               CLR_POS = 1'b1,
  parameter bit               EN_POS  = 1'b1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             edge_i,
  input  logic [WIDTH-1:0] past_d,
  input  logic [WIDTH-1:0] past_q,
  input  logic [WIDTH-1:0] d,
  input  logic             en,
  input  logic             arst,
  input  logic [WIDTH-1:0] bit_set,
  input  logic [WIDTH-1:0] bit_clr,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] base;
  logic [WIDTH-1:0] set_act;
  logic [WIDTH-1:0] clr_act;
  logic             unused_inputs;

  assign base    = edge_i ? past_d : past_q;
  assign set_act = SET_POS ? bit_set : ~bit_set;
  assign clr_act = CLR_POS ? bit_clr : ~bit_clr;

  if (MODE == GCE_FLOP) begin : g_flop
    assign q = base;
    assign unused_inputs = ^{d, en, arst, set_act, clr_act};
  end else if (MODE == GCE_FLOP_ARST) begin : g_arst
    assign q = (arst == RST_POS) ? RST_VAL : base;
    assign unused_inputs = ^{d, en, set_act, clr_act};
  end else if (MODE == GCE_FLOP_SR) begin : g_sr
    assign q = (base | set_act) & ~clr_act;
    assign unused_inputs = ^{d, en, arst};
  end else begin : g_latch
    assign q = (en == EN_POS) ? d : past_q;
    assign unused_inputs = ^{base, arst, set_act, clr_act};
  end

endmodule

// File: rtl/gclk_store_emu.sv
// Storage element emulated on a single global sampling clock.
module gclk_store_emu
  import gce_pkg::*;
#(
  parameter gce_mode_e        MODE      = GCE_FLOP,
  parameter int               WIDTH     = 8,
  parameter bit               CLK_POS   = 1'b1,
  parameter bit               RST_POS   = 1'b1,
  parameter bit               SET_POS   = 1'b1,
  parameter bit               CLR_POS   = 1'b1,
  parameter bit               EN_POS    = 1'b1,
  parameter logic [WIDTH-1:0] RST_VAL   = '0,
  parameter logic [WIDTH-1:0] INIT_VAL  = '0,
  parameter logic [WIDTH-1:0] INIT_MASK = '1
) (
  input  logic             gclk,
  input  logic             grst_n,
  input  logic             dclk,
  input  logic [WIDTH-1:0] d,
  input  logic             en,
  input  logic             arst,
  input  logic [WIDTH-1:0] bit_set,
  input  logic [WIDTH-1:0] bit_clr,
  output logic [WIDTH-1:0] q
);

  localparam bit IS_FLOP = (MODE != GCE_LATCH);

  logic             clk_edge;
  logic [WIDTH-1:0] past_d;
  logic [WIDTH-1:0] past_q;

  if (IS_FLOP) begin : g_flop_path
    gce_edge #(.CLK_POS(CLK_POS)) u_edge (
      .gclk   (gclk),
      .grst_n (grst_n),
      .dclk   (dclk),
      .edge_o (clk_edge)
    );
    gce_hold #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL), .INIT_MASK(INIT_MASK)) u_dhold (
      .gclk   (gclk),
      .grst_n (grst_n),
      .din    (d),
      .dout   (past_d)
    );
  end else begin : g_latch_path
    logic unused_dclk;
    assign unused_dclk = dclk;
    assign clk_edge    = 1'b0;
    assign past_d      = '0;
  end

  gce_hold #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL), .INIT_MASK(INIT_MASK)) u_qhold (
    .gclk   (gclk),
    .grst_n (grst_n),
    .din    (q),
    .dout   (past_q)
  );

  gce_qsel #(
    .MODE    (MODE),
    .WIDTH   (WIDTH),
    .RST_POS (RST_POS),
    .SET_POS (SET_POS),
    .CLR_POS (CLR_POS),
    .EN_POS  (EN_POS),
    .RST_VAL (RST_VAL)
  ) u_qsel (
    .edge_i  (clk_edge),
    .past_d  (past_d),
    .past_q  (past_q),
    .d       (d),
    .en      (en),
    .arst    (arst),
    .bit_set (bit_set),
    .bit_clr (bit_clr),
    .q       (q)
  );

endmodule

// File: rtl/gce_emu_chk.sv
// Port-level properties of the emulated element, attached by bind.
module gce_emu_chk
  import gce_pkg::*;
#(
  parameter gce_mode_e        MODE      = GCE_FLOP,
  parameter int               WIDTH     = 8,
  parameter bit               CLK_POS   = 1'b1,
  parameter bit               RST_POS   = 1'b1,
  parameter bit               SET_POS   = 1'b1,
  parameter bit               CLR_POS   = 1'b1,
  parameter bit               EN_POS    = 1'b1,
  parameter logic [WIDTH-1:0] RST_VAL   = '0,
  parameter logic [WIDTH-1:0] INIT_VAL  = '0,
  parameter logic [WIDTH-1:0] INIT_MASK = '1
) (
  input logic             gclk,
  input logic             grst_n,
  input logic             dclk,
  input logic [WIDTH-1:0] d,
  input logic             en,
  input logic             arst,
  input logic [WIDTH-1:0] bit_set,
  input logic [WIDTH-1:0] bit_clr,
  input logic [WIDTH-1:0] q
);

  logic             seen;
  logic             p_dclk;
  logic [WIDTH-1:0] p_d;
  logic [WIDTH-1:0] p_q;
  logic             act_edge;
  logic             rev_edge;
  logic             ovr;
  logic             en_act;
  logic [WIDTH-1:0] s_act;
  logic [WIDTH-1:0] c_act;
  logic             unused_chk;

  always_ff @(posedge gclk or negedge grst_n) begin
    if (!grst_n) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  always_ff @(posedge gclk) begin
    p_dclk <= dclk;
    p_d    <= d;
    p_q    <= q;
  end

  assign act_edge = (p_dclk != CLK_POS) && (dclk == CLK_POS);
  assign rev_edge = (p_dclk == CLK_POS) && (dclk != CLK_POS);
  assign s_act    = SET_POS ? bit_set : ~bit_set;
  assign c_act    = CLR_POS ? bit_clr : ~bit_clr;
  assign en_act   = (en == EN_POS);
  assign ovr      = ((MODE == GCE_FLOP_ARST) && (arst == RST_POS)) ||
                    ((MODE == GCE_FLOP_SR) && (|(s_act | c_act)));
  assign unused_chk = ^{en_act, act_edge, rev_edge, ovr, p_d, s_act, c_act,
                        INIT_VAL, INIT_MASK};

  if (MODE != GCE_LATCH) begin : g_flop_props
    // R2
    r2_rev_hold_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      (seen && rev_edge && !ovr) |-> (q == p_q));
    // R3
    r3_capture_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      (seen && act_edge && !ovr) |-> (q == p_d));
    // R4
    r4_hold_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      (seen && !act_edge && !ovr) |-> (q == p_q));
  end

  if (MODE == GCE_FLOP_ARST) begin : g_arst_props
    // R5
    r5_force_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      (arst == RST_POS) |-> (q == RST_VAL));
  end

  if (MODE == GCE_FLOP_SR) begin : g_sr_props
    // R6
    r6_clr_wins_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      seen |-> ((q & c_act) == '0));
    // R6
    r6_set_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      seen |-> ((q & s_act & ~c_act) == (s_act & ~c_act)));
  end

  if (MODE == GCE_LATCH) begin : g_latch_props
    // R7
    r7_pass_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      en_act |-> (q == d));
    // R8
    r8_hold_chk: assert property (@(posedge gclk) disable iff (!grst_n)
      (seen && !en_act) |-> (q == p_q));
  end

endmodule

bind gclk_store_emu gce_emu_chk #(
  .MODE      (MODE),
  .WIDTH     (WIDTH),
  .CLK_POS   (CLK_POS),
  .RST_POS   (RST_POS),
  .SET_POS   (SET_POS),
  .CLR_POS   (CLR_POS),
  .EN_POS    (EN_POS),
  .RST_VAL   (RST_VAL),
  .INIT_VAL  (INIT_VAL),
  .INIT_MASK (INIT_MASK)
) u_chk (
  .gclk    (gclk),
  .grst_n  (grst_n),
  .dclk    (dclk),
  .d       (d),
  .en      (en),
  .arst    (arst),
  .bit_set (bit_set),
  .bit_clr (bit_clr),
  .q       (q)
);

// File: tb/gclk_store_emu_tb.sv
`timescale 1ns/1ps
module gclk_store_emu_tb;
  import gce_pkg::*;

  localparam int         W    = 8;
  localparam int         NI   = 8;
  localparam logic [W-1:0] INIT = 8'hA5;
  localparam logic [W-1:0] RSTV = 8'h3C;
  localparam gce_mode_e MODES [NI] = '{GCE_FLOP, GCE_FLOP, GCE_FLOP_ARST, GCE_FLOP_ARST,
                                       GCE_FLOP_SR, GCE_FLOP_SR, GCE_LATCH, GCE_LATCH};
  // Polarity per instance, bit k for instance k
  localparam bit [NI-1:0] CPOL = 8'b1101_0101;
  localparam bit [NI-1:0] RPOL = 8'b1111_0111;
  localparam bit [NI-1:0] SPOL = 8'b1101_1111;
  localparam bit [NI-1:0] EPOL = 8'b0111_1111;

  logic gclk = 1'b0;
  logic grst_n = 1'b0;
  logic dclk, en, arst;
  logic [W-1:0] d, bit_set, bit_clr;
  logic [W-1:0] q_all [NI];

  logic [W-1:0] exp_q [NI];
  logic [W-1:0] hq [NI];
  logic         hc;
  logic [W-1:0] hd;
  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 gclk = ~gclk;

  for (genvar k = 0; k < NI; k++) begin : g_inst
    gclk_store_emu #(
      .MODE(MODES[k]), .WIDTH(W), .CLK_POS(CPOL[k]), .RST_POS(RPOL[k]),
      .SET_POS(SPOL[k]), .CLR_POS(SPOL[k]), .EN_POS(EPOL[k]),
      .RST_VAL(RSTV), .INIT_VAL(INIT), .INIT_MASK(8'hFF)
    ) u_dut (
      .gclk(gclk), .grst_n(grst_n), .dclk(dclk), .d(d), .en(en), .arst(arst),
      .bit_set(bit_set), .bit_clr(bit_clr), .q(q_all[k])
    );
  end

  function automatic bit is_edge(int k, logic prev);
    return (prev != CPOL[k]) && (dclk == CPOL[k]);
  endfunction

  // Behavioural reference of each element from the requirements
  function automatic logic [W-1:0] model(int k, logic prev, logic [W-1:0] pd, logic [W-1:0] pq);
    logic [W-1:0] base, sa, ca;
    base = is_edge(k, prev) ? pd : pq;
    sa = SPOL[k] ? bit_set : ~bit_set;
    ca = SPOL[k] ? bit_clr : ~bit_clr;
    case (MODES[k])
      GCE_FLOP_ARST: return (arst == RPOL[k]) ? RSTV : base;
      GCE_FLOP_SR:   return (base | sa) & ~ca;
      GCE_LATCH:     return (en == EPOL[k]) ? d : pq;
      default:       return base;
    endcase
  endfunction

  function automatic string tag_of(int k);
    logic [W-1:0] sa, ca;
    sa = SPOL[k] ? bit_set : ~bit_set;
    ca = SPOL[k] ? bit_clr : ~bit_clr;
    if (MODES[k] == GCE_LATCH) return (en == EPOL[k]) ? "R7" : "R8";
    if (MODES[k] == GCE_FLOP_ARST && arst == RPOL[k]) return "R5";
    if (MODES[k] == GCE_FLOP_SR && |(sa | ca)) return "R6";
    return is_edge(k, hc) ? "R3" : "R4";
  endfunction

  task automatic check_all(string tag);
    string t;
    for (int k = 0; k < NI; k++) begin
      t = (tag.len() != 0) ? tag : tag_of(k);
      checks++;
      if (q_all[k] !== exp_q[k]) begin
        bad++;
        $display("FAIL %s inst%0d q=%h expected=%h", t, k, q_all[k], exp_q[k]);
      end
    end
  endtask

  task automatic drive(logic c, logic [W-1:0] dv, logic e, logic ar,
                       logic [W-1:0] sv, logic [W-1:0] cv, string tag);
    @(posedge gclk);
    hc = dclk;
    hd = d;
    for (int k = 0; k < NI; k++) hq[k] = exp_q[k];
    @(negedge gclk);
    dclk = c; d = dv; en = e; arst = ar; bit_set = sv; bit_clr = cv;
    for (int k = 0; k < NI; k++) exp_q[k] = model(k, hc, hd, hq[k]);
    #1 check_all(tag);
  endtask

  initial begin
    logic [31:0] r;
    logic [W-1:0] sp_s, sp_c;
    logic ar, ph;
    r = $urandom(32'd2718);
    dclk = 1'b1; d = 8'h5A; en = 1'b0; arst = 1'b0; bit_set = '0; bit_clr = '0;
    repeat (3) @(posedge gclk);
    @(negedge gclk);
    // R1: initial load, clock held high then low, no false edge
    for (int k = 0; k < NI; k++) exp_q[k] = model(k, CPOL[k], INIT, INIT);
    #1 check_all("R1");
    @(negedge gclk);
    dclk = 1'b0; d = 8'hC3;
    for (int k = 0; k < NI; k++) exp_q[k] = model(k, CPOL[k], INIT, INIT);
    #1 check_all("R1");
    @(negedge gclk);
    grst_n = 1'b1;
    #1 check_all("R1");

    // R2: falling then rising transitions on both clock polarities
    drive(1'b1, 8'h11, 1'b0, 1'b1, 8'hFF, 8'h00, "R2");
    drive(1'b0, 8'h22, 1'b0, 1'b1, 8'hFF, 8'h00, "R2");
    drive(1'b1, 8'h33, 1'b0, 1'b1, 8'hFF, 8'h00, "R2");
    drive(1'b1, 8'h44, 1'b0, 1'b1, 8'hFF, 8'h00, "R2");
    // R5: assert then release async reset, clock held
    drive(1'b1, 8'h55, 1'b0, 1'b1, 8'hFF, 8'h00, "R5");
    drive(1'b1, 8'h66, 1'b0, 1'b0, 8'hFF, 8'h00, "R5");
    drive(1'b1, 8'h77, 1'b0, 1'b1, 8'hFF, 8'h00, "R5");
    // R6: set and clear together, clear wins
    drive(1'b0, 8'h88, 1'b1, 1'b0, 8'hFF, 8'hFF, "R6");
    drive(1'b1, 8'h99, 1'b1, 1'b0, 8'h0F, 8'hF0, "R6");
    drive(1'b1, 8'h9A, 1'b1, 1'b0, 8'h00, 8'h00, "R6");
    // R9: opposite polarities of enable and reset on paired instances
    drive(1'b0, 8'hAB, 1'b0, 1'b0, 8'hFF, 8'h00, "R9");
    drive(1'b0, 8'hBC, 1'b1, 1'b1, 8'hFF, 8'h00, "R9");
    drive(1'b1, 8'hCD, 1'b0, 1'b0, 8'h00, 8'hFF, "R9");

    for (int i = 0; i < 3000; i++) begin
      ph = (i / 64) % 2 == 1;
      r = $urandom; sp_s = r[7:0] & r[15:8] & r[23:16];
      r = $urandom; sp_c = r[7:0] & r[15:8] & r[23:16];
      r = $urandom;
      ar = (r[3:0] == 4'd0);
      drive(r[4] ? ~dclk : dclk, r[15:8], r[5], ph ? ~ar : ar,
            ph ? ~sp_s : sp_s, ph ? ~sp_c : sp_c, "");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge gclk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule